// File: doc/BRIEF.md
# Error-Shifted Ramp Pulse-Width Modulator

This block produces the switch-control pulse of a voltage-mode buck converter loop. It uses a counter-against-compare scheme. Each switching period it receives two signed values. One is a duty command from an external digital compensator. The other is the current output-voltage error sample. From the error it forms a shift term and adds it to the compensator's command. In effect this moves the digital ramp down for a positive error and up for a negative one, so the loop recovers faster after a load step.

The shift is a programmable polynomial in the error with a linear and a square coefficient. Both coefficients are signed fixed point. A programmable deadband sets the shift to zero when the error is small, so steady-state regulation is left to the compensator alone. The summed command is clamped to the period and held in a register that only updates when the counter wraps. The compare level therefore never moves inside a period. The counter period is an input, so the same logic covers a 100 kHz switching rate from any practical system clock.

Top module: `shifted_ramp_dpwm`

## Requirements
- R1: The counter runs 0, 1, …, period−1 and then wraps to 0. `pwm_out` is high exactly while the counter is below the held command, so each period has as many high cycles as the value on `duty_applied`.
- R2: The next command is duty_in + floor((k1·e + k2·e²) / 2^10). Here e is `err_in`, `duty_in` and `err_in` are signed 12-bit integers in counter steps, and k1 and k2 are signed 16-bit values with 10 fraction bits.
- R3: With a positive linear coefficient, a positive error raises the command above `duty_in` (ramp moved down) and a negative error lowers it (ramp moved up).
- R4: When |err_in| ≤ `band` (unsigned), the shift term is zero and `duty_in` passes through unchanged. One step beyond the band, the shift applies.
- R5: The square term is programmed on its own through k2. It adds the same amount for +e and −e, and it sums with the linear term before the single floor.
- R6: The summed command is clamped to [0, period]. A command of 0 gives a constantly low output and a command equal to the period gives a constantly high output, including for negative or oversized `duty_in`.
- R7: The held command loads only at the counter wrap. Changes to `duty_in`, `err_in` or the coefficients in mid-period do not alter the current pulse and take effect from the next period.
- R8: A synchronous reset sets the counter and the held command to zero and forces `pwm_out` low.
- R9: Negative gains down to −12.0 and positive gains up to about +0.8 are representable. Non-integer products round toward minus infinity (e.g. −1.25·5 gives −7, 0.8·10 gives +7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period | input | CNT_W | Counter steps per switching period |
| duty_in | input | DUTY_W | Signed compensator duty, counter steps |
| err_in | input | ERR_W | Signed voltage error sample |
| k1 | input | COEF_W | Signed linear shift gain, COEF_FRAC fraction bits |
| k2 | input | COEF_W | Signed square shift gain, COEF_FRAC fraction bits |
| band | input | ERR_W | Unsigned steady-state error threshold |
| pwm_out | output | 1 | Switch-control pulse |
| duty_applied | output | CNT_W | Compare level held for the current period |

## Verification
Two functions can fall in the same cycle: the wrap that loads a new compare level, and an input change that would alter that level. The bench provokes this by changing `duty_in` several counts into a period. It then judges the high-cycle count of the running pulse and the held level against the old command, and checks that the next period shows the new one. A second coincidence is saturation acting together with the deadband edge. Vectors that sit exactly on the band, one step past it, and far beyond the period are each judged both by pulse width and by the held level.

// File: rtl/sdpwm_pkg.sv
`timescale 1ns/1ps
package sdpwm_pkg;
  // error zone classification of one sample
  typedef enum logic {
    ZONE_STEADY    = 1'b0,
    ZONE_TRANSIENT = 1'b1
  } err_zone_e;

  localparam int unsigned COEF_FRAC_DEFAULT = 10;
endpackage

// File: rtl/sdpwm_shift.sv
`timescale 1ns/1ps
module sdpwm_shift #(
  parameter int ERR_W     = 12,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 10,
  parameter int ACC_W     = 2*ERR_W + COEF_W + 2
) (
  input  logic signed [ERR_W-1:0]  err,
  input  logic signed [COEF_W-1:0] k1,
  input  logic signed [COEF_W-1:0] k2,
  input  logic        [ERR_W-1:0]  band,
  output logic signed [ACC_W-1:0]  shift
);
  import sdpwm_pkg::*;

  // magnitude of a signed error, one bit wider so the most negative value fits
  function automatic logic [ERR_W:0] err_mag(input logic signed [ERR_W-1:0] e);
    logic signed [ERR_W:0] ex;
    ex = e;
    return ex[ERR_W] ? $unsigned(-ex) : $unsigned(ex);
  endfunction

  // floor((k1*e + k2*e*e) / 2^COEF_FRAC) with full-width products
  function automatic logic signed [ACC_W-1:0] poly_eval(
    input logic signed [ERR_W-1:0]  e,
    input logic signed [COEF_W-1:0] c1,
    input logic signed [COEF_W-1:0] c2);
    logic signed [ACC_W-1:0] ex, c1x, c2x, sq, acc;
    ex  = e;
    c1x = c1;
    c2x = c2;
    sq  = ex * ex;
    acc = (c1x * ex) + (c2x * sq);
    return acc >>> COEF_FRAC;
  endfunction

  err_zone_e zone;

  always_comb begin
    zone  = (err_mag(err) <= {1'b0, band}) ? ZONE_STEADY : ZONE_TRANSIENT;
    shift = (zone == ZONE_STEADY) ? '0 : poly_eval(err, k1, k2);
  end
endmodule

// File: rtl/sdpwm_sum_clamp.sv
`timescale 1ns/1ps
module sdpwm_sum_clamp #(
  parameter int DUTY_W = 12,
  parameter int CNT_W  = 10,
  parameter int ACC_W  = 42
) (
  input  logic signed [DUTY_W-1:0] duty,
  input  logic signed [ACC_W-1:0]  shift,
  input  logic        [CNT_W-1:0]  period,
  output logic        [CNT_W-1:0]  cmd
);
  localparam int PAD_W = ACC_W - CNT_W;

  // limit a wide signed sum to the closed range [0, per]
  function automatic logic [CNT_W-1:0] clamp_cmd(
    input logic signed [ACC_W-1:0] total,
    input logic        [CNT_W-1:0] per);
    logic signed [ACC_W-1:0] per_x;
    per_x = $signed({{PAD_W{1'b0}}, per});
    if (total < 0)          return '0;
    else if (total > per_x) return per;
    else                    return total[CNT_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] duty_x;
  logic signed [ACC_W-1:0] total;

  always_comb begin
    duty_x = duty;
    total  = duty_x + shift;
    cmd    = clamp_cmd(total, period);
  end
endmodule

// File: rtl/sdpwm_ramp.sv
`timescale 1ns/1ps
module sdpwm_ramp #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmd_next,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic [CNT_W-1:0] cmd_q,
  output logic             pwm
);
  logic [CNT_W:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  assign wrap    = (cnt_inc >= {1'b0, period});
  assign pwm     = (cnt < cmd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmd_q <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      cmd_q <= cmd_next;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/shifted_ramp_dpwm.sv
`timescale 1ns/1ps
module shifted_ramp_dpwm #(
  parameter int CNT_W     = 10,
  parameter int DUTY_W    = 12,
  parameter int ERR_W     = 12,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = sdpwm_pkg::COEF_FRAC_DEFAULT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic        [CNT_W-1:0]  period,
  input  logic signed [DUTY_W-1:0] duty_in,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic signed [COEF_W-1:0] k1,
  input  logic signed [COEF_W-1:0] k2,
  input  logic        [ERR_W-1:0]  band,
  output logic                     pwm_out,
  output logic        [CNT_W-1:0]  duty_applied
);
  localparam int ACC_W = 2*ERR_W + COEF_W + 2;

  logic signed [ACC_W-1:0] shift_w;
  logic        [CNT_W-1:0] cmd_next_w;
  logic        [CNT_W-1:0] cnt_w;
  logic                    wrap_w;

  sdpwm_shift #(
    .ERR_W(ERR_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .ACC_W(ACC_W)
  ) shift_i (
    .err(err_in), .k1(k1), .k2(k2), .band(band), .shift(shift_w)
  );

  sdpwm_sum_clamp #(
    .DUTY_W(DUTY_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) clamp_i (
    .duty(duty_in), .shift(shift_w), .period(period), .cmd(cmd_next_w)
  );

  sdpwm_ramp #(
    .CNT_W(CNT_W)
  ) ramp_i (
    .clk(clk), .rst(rst), .period(period), .cmd_next(cmd_next_w),
    .cnt(cnt_w), .wrap(wrap_w), .cmd_q(duty_applied), .pwm(pwm_out)
  );
endmodule

// File: rtl/sdpwm_chk.sv
`timescale 1ns/1ps
module sdpwm_chk #(
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 12,
  parameter int ERR_W  = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic        [CNT_W-1:0]  period,
  input logic signed [DUTY_W-1:0] duty_in,
  input logic signed [ERR_W-1:0]  err_in,
  input logic        [ERR_W-1:0]  band,
  input logic                     pwm_out,
  input logic        [CNT_W-1:0]  duty_applied,
  input logic        [CNT_W-1:0]  cnt_w,
  input logic                     wrap_w
);
  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt_w == '0 && duty_applied == '0 && !pwm_out));

  // R7
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_w |=> $stable(duty_applied));

  // R1
  wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> (cnt_w == '0));

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_applied == '0) |-> !pwm_out);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> (int'(duty_applied) <= int'($past(period))));

  // R4
  band_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_w && abs_i(int'(err_in)) <= int'(band) && duty_in >= 0
     && int'(duty_in) <= int'(period))
    |=> (int'(duty_applied) == int'($past(duty_in))));
endmodule

bind shifted_ramp_dpwm sdpwm_chk #(
  .CNT_W(CNT_W), .DUTY_W(DUTY_W), .ERR_W(ERR_W)
) chk_i (
  .clk(clk), .rst(rst), .period(period), .duty_in(duty_in), .err_in(err_in),
  .band(band), .pwm_out(pwm_out), .duty_applied(duty_applied),
  .cnt_w(cnt_w), .wrap_w(wrap_w)
);

// File: tb/shifted_ramp_dpwm_tb_top.sv
`timescale 1ns/1ps
module shifted_ramp_dpwm_tb_top;
  localparam int P = 20;

  typedef struct packed {
    logic signed [11:0] duty;
    logic signed [11:0] err;
    logic signed [15:0] k1;
    logic signed [15:0] k2;
    logic        [11:0] band;
    logic        [9:0]  exp;
    logic        [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{ 12'sd8,   12'sd0,    16'sd1024,   16'sd0,   12'd4, 10'd8,  4'd2 }, // R2 no error
    '{ 12'sd8,   12'sd6,    16'sd1024,   16'sd0,   12'd4, 10'd14, 4'd3 }, // R3 ramp down
    '{ 12'sd8,  -12'sd6,    16'sd1024,   16'sd0,   12'd4, 10'd2,  4'd3 }, // R3 ramp up
    '{ 12'sd8,   12'sd4,    16'sd1024,   16'sd0,   12'd4, 10'd8,  4'd4 }, // R4 on band edge
    '{ 12'sd8,   12'sd5,    16'sd1024,   16'sd0,   12'd4, 10'd13, 4'd4 }, // R4 one past band
    '{ 12'sd10, -12'sd5,   -16'sd1280,   16'sd0,   12'd4, 10'd16, 4'd9 }, // R9 -1.25 gain
    '{ 12'sd10,  12'sd5,   -16'sd1280,   16'sd0,   12'd4, 10'd3,  4'd9 }, // R9 floor to -7
    '{ 12'sd4,   12'sd6,    16'sd0,      16'sd256, 12'd4, 10'd13, 4'd5 }, // R5 square only
    '{ 12'sd4,  -12'sd6,    16'sd0,      16'sd256, 12'd4, 10'd13, 4'd5 }, // R5 even term
    '{ 12'sd4,   12'sd6,    16'sd1024,   16'sd256, 12'd4, 10'd19, 4'd5 }, // R5 both terms
    '{ 12'sd15,  12'sd100,  16'sd1024,   16'sd0,   12'd4, 10'd20, 4'd6 }, // R6 clamp high
    '{ 12'sd5,  -12'sd100,  16'sd1024,   16'sd0,   12'd4, 10'd0,  4'd6 }, // R6 clamp low
    '{-12'sd3,   12'sd0,    16'sd1024,   16'sd0,   12'd4, 10'd0,  4'd6 }, // R6 negative duty
    '{ 12'sd30,  12'sd0,    16'sd1024,   16'sd0,   12'd4, 10'd20, 4'd6 }, // R6 oversized duty
    '{ 12'sd8,   12'sd1,    16'sd1024,   16'sd0,   12'd0, 10'd9,  4'd4 }, // R4 zero band
    '{ 12'sd15,  12'sd1,   -16'sd12288,  16'sd0,   12'd0, 10'd3,  4'd9 }, // R9 -12 gain
    '{ 12'sd2,   12'sd10,   16'sd819,    16'sd0,   12'd0, 10'd9,  4'd9 }  // R9 +0.8 gain
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [9:0]         period = 10'(P);
  logic signed [11:0] duty_in = '0;
  logic signed [11:0] err_in = '0;
  logic signed [15:0] k1 = '0;
  logic signed [15:0] k2 = '0;
  logic [11:0]        band = '0;
  logic               pwm_out;
  logic [9:0]         duty_applied;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int ph = 0;

  shifted_ramp_dpwm dut_i (
    .clk(clk), .rst(rst), .period(period), .duty_in(duty_in), .err_in(err_in),
    .k1(k1), .k2(k2), .band(band), .pwm_out(pwm_out), .duty_applied(duty_applied)
  );

  always #4 clk = ~clk;

  // bench's own view of the period phase
  always @(posedge clk) begin
    if (rst) ph <= 0;
    else     ph <= (ph == P-1) ? 0 : ph + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_phase0();
    @(negedge clk);
    while (ph != 0) @(negedge clk);
  endtask

  // count high samples over one full period, starting at phase 0
  task automatic measure(output int highs);
    highs = 0;
    for (int i = 0; i < P; i++) begin
      if (i != 0) @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    // R8 state under reset
    check("R8 level in reset", int'(duty_applied), 0);
    check("R8 output in reset", int'(pwm_out), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      duty_in = VECS[v].duty;
      err_in  = VECS[v].err;
      k1      = VECS[v].k1;
      k2      = VECS[v].k2;
      band    = VECS[v].band;
      wait_phase0();
      check($sformatf("R%0d level v%0d", VECS[v].rq, v), int'(duty_applied), int'(VECS[v].exp));
      measure(hi);
      // R1 pulse width equals held level
      check($sformatf("R1/R%0d width v%0d", VECS[v].rq, v), hi, int'(VECS[v].exp));
    end

    // R7 mid-period change has no effect until the wrap
    @(negedge clk);
    duty_in = 12'sd8; err_in = '0; k1 = '0; k2 = '0; band = 12'd4;
    wait_phase0();
    wait_phase0();
    hi = 0;
    for (int i = 0; i < P; i++) begin
      if (i != 0) @(negedge clk);
      if (pwm_out) hi++;
      if (i == 4) begin
        duty_in = 12'sd15;
        err_in  = 12'sd9;
        k1      = 16'sd1024;
      end
    end
    check("R7 width after mid change", hi, 8);
    check("R7 level held", int'(duty_applied), 8);
    wait_phase0();
    check("R7 new level next period", int'(duty_applied), 24 > P ? P : 24);

    // R8 reset in mid-run
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 level after reset", int'(duty_applied), 0);
    check("R8 output after reset", int'(pwm_out), 0);
    rst = 1'b0;
    duty_in = 12'sd5; err_in = '0;
    wait_phase0();
    check("R8 restart level", int'(duty_applied), 5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule